// File: doc/BRIEF.md
# Edge-Qualified Counter Capture Unit

This block watches an asynchronous input pin and, when that pin makes a qualified transition, stores the present value of an external free-running counter. The stored value is then available for timing measurement. Edge polarity can be selected, and an optional digital filter can be switched on. When the filter is on, the pin must hold its new level for several consecutive system-clock samples before the transition counts. The counter itself, any interrupt logic and any register access lie outside the block.

The pin first passes through a synchronizer chain. A level register then tracks the pin. In unfiltered mode it follows every synchronized sample. In filtered mode it changes only when a full window of samples agrees on the opposite level. A capture fires when this level register moves to the level chosen by the polarity input. In that same clock edge the counter value is loaded and the flag output rises for exactly one cycle. The flag is a plain pulse with no back-pressure. A consumer that misses it can still read the held value, which stays until the next capture.

Top module: `icu_capture_unit`

## Requirements
- R1: After reset the captured value is 0, the flag is low and the internal level is low, so a pin held low produces no capture.
- R2: With the polarity input at 1 (rising) and the filter off, a pin rise driven before clock edge P0 raises the flag after edge P2 and not before. The captured value is the counter input sampled at P2.
- R3: With the polarity input at 0 (falling) and the filter off, a pin fall is captured with the same three-edge latency as in R2.
- R4: A pin transition opposite to the selected polarity causes no flag and leaves the captured value unchanged.
- R5: The flag is high for exactly one cycle per capture. The captured value changes only in a cycle in which the flag rises, and it holds until the next capture.
- R6: With the filter on, a pin change held for at least 4 system-clock cycles is accepted. For a qualifying edge driven before P0 the flag rises after P5, and the captured value is the counter input at P5.
- R7: With the filter on, a pulse at the target level lasting only 3 cycles produces no capture. A pulse lasting exactly 4 cycles does capture.
- R8: With the filter on, once the level has settled, a dropout of fewer than 4 cycles does not change it, so the pin's return produces no second capture.
- R9: Changing the polarity input while the pin is steady produces no capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; also the filter's sample clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| count_i | input | CNT_W (16) | Free-running counter value to be stored |
| edge_rise_i | input | 1 | Polarity: 1 captures on rising, 0 on falling |
| filt_en_i | input | 1 | 1 enables the agreeing-samples filter |
| cap_value_o | output | CNT_W (16) | Most recently captured counter value |
| cap_flag_o | output | 1 | One-cycle pulse in the cycle the value is loaded |

## Verification
A level register stuck at the wrong value shows up at the next qualifying edge. The capture either goes missing, or it appears on the opposite transition within three cycles of the pin change. A synchronizer or filter window of the wrong length does not hide: the flag then rises one or more cycles early or late, and the captured counter value moves away from the expected sample. The counter stimulus advances by a fixed step every cycle, so every cycle of latency error is visible in the stored value as well as in the flag timing. A filter that treats the two directions unequally is caught by the glitch and dropout scenarios. In those cases a spurious flag appears within a few cycles of the short pulse ending.

// File: rtl/icu_pkg.sv
package icu_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_pol_e;

  localparam int unsigned DEF_CNT_W       = 16;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_FILT_LEN    = 4;
endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= async_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/icu_filter.sv
module icu_filter #(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic sample_i,
  input  logic filt_en_i,
  output logic level_o,
  output logic level_next_o
);
  localparam int unsigned HIST_W = FILT_LEN - 1;

  logic [HIST_W-1:0]   hist_q;
  logic [FILT_LEN-1:0] window;
  logic                level_q;
  logic                level_d;

  assign window = {hist_q, sample_i};

  always_comb begin
    level_d = level_q;
    if (!filt_en_i)        level_d = sample_i;
    else if (&window)      level_d = 1'b1;
    else if (~|window)     level_d = 1'b0;
  end

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      hist_q  <= '0;
      level_q <= 1'b0;
    end else begin
      hist_q  <= window[HIST_W-1:0];
      level_q <= level_d;
    end
  end

  assign level_o      = level_q;
  assign level_next_o = level_d;

  // R6: any change of the level agrees with the sample that produced it
  a_r6_level_follows_sample: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(level_q) |-> ($past(sample_i) == level_q));
endmodule

// File: rtl/icu_latch.sv
module icu_latch #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             level_i,
  input  logic             level_next_i,
  input  logic             edge_rise_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] value_o,
  output logic             flag_o
);
  import icu_pkg::*;

  edge_pol_e   pol;
  logic        hit;
  logic [CNT_W-1:0] value_q;
  logic        flag_q;

  assign pol = edge_pol_e'(edge_rise_i);
  assign hit = (level_next_i != level_i) && (level_next_i == logic'(pol));

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      value_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      flag_q <= hit;
      if (hit) value_q <= count_i;
    end
  end

  assign value_o = value_q;
  assign flag_o  = flag_q;

  // R5: the flag never lasts two cycles
  a_r5_flag_single: assert property (@(posedge clk_i) disable iff (rst_i)
    flag_q |=> !flag_q);
  // R5: the stored value moves only together with the flag
  a_r5_value_held: assert property (@(posedge clk_i) disable iff (rst_i)
    (value_q != $past(value_q)) |-> flag_q);
  // R3: a capture leaves the level at the selected polarity
  a_r3_flag_polarity: assert property (@(posedge clk_i) disable iff (rst_i)
    flag_q |-> (level_i == $past(edge_rise_i)));
endmodule

// File: rtl/icu_capture_unit.sv
module icu_capture_unit #(
  parameter int unsigned CNT_W       = icu_pkg::DEF_CNT_W,
  parameter int unsigned SYNC_STAGES = icu_pkg::DEF_SYNC_STAGES,
  parameter int unsigned FILT_LEN    = icu_pkg::DEF_FILT_LEN
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             cap_pin_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             edge_rise_i,
  input  logic             filt_en_i,
  output logic [CNT_W-1:0] cap_value_o,
  output logic             cap_flag_o
);
  logic pin_sync;
  logic level_q;
  logic level_d;

  icu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .async_i (cap_pin_i),
    .sync_o  (pin_sync)
  );

  icu_filter #(.FILT_LEN(FILT_LEN)) u_filter (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .sample_i     (pin_sync),
    .filt_en_i    (filt_en_i),
    .level_o      (level_q),
    .level_next_o (level_d)
  );

  icu_latch #(.CNT_W(CNT_W)) u_latch (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .level_i      (level_q),
    .level_next_i (level_d),
    .edge_rise_i  (edge_rise_i),
    .count_i      (count_i),
    .value_o      (cap_value_o),
    .flag_o       (cap_flag_o)
  );
endmodule

// File: tb/test_icu_capture_unit.sv
`timescale 1ns/1ps
module test_icu_capture_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin = 1'b0;
  logic [15:0] cnt = 16'd100;
  logic        sel = 1'b1;
  logic        fen = 1'b0;
  logic [15:0] val;
  logic        flag;
  int          total = 0;
  int          failed = 0;
  logic [15:0] last;

  always #4 clk = ~clk;
  always @(negedge clk) cnt <= cnt + 16'd3;

  icu_capture_unit i_icu_capture_unit (
    .clk_i(clk), .rst_i(rst), .cap_pin_i(pin), .count_i(cnt),
    .edge_rise_i(sel), .filt_en_i(fen), .cap_value_o(val), .cap_flag_o(flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      step(1);
      chk(flag == 1'b0, req, flag, 0);
      chk(val == last, req, val, last);
    end
  endtask

  task automatic t_reset;
    step(1);
    chk(val == 16'd0, "R1 value", val, 0);
    chk(flag == 1'b0, "R1 flag", flag, 0);
    last = val;
    quiet(4, "R1 idle");
  endtask

  task automatic t_rise;
    logic [15:0] c0;
    sel = 1'b1; fen = 1'b0;
    pin = 1'b1; c0 = cnt;
    step(2);
    chk(flag == 1'b0, "R2 early", flag, 0);
    step(1);
    chk(flag == 1'b1, "R2 flag", flag, 1);
    chk(val == 16'(c0 + 16'd6), "R2 value", val, 16'(c0 + 16'd6));
    last = val;
    step(1);
    chk(flag == 1'b0, "R5 one cycle", flag, 0);
    chk(val == last, "R5 held", val, last);
  endtask

  task automatic t_fall;
    logic [15:0] c0;
    pin = 1'b0;
    quiet(6, "R4 opposite fall");
    sel = 1'b0;
    pin = 1'b1;
    quiet(6, "R4 opposite rise");
    pin = 1'b0; c0 = cnt;
    step(2);
    chk(flag == 1'b0, "R3 early", flag, 0);
    step(1);
    chk(flag == 1'b1, "R3 flag", flag, 1);
    chk(val == 16'(c0 + 16'd6), "R3 value", val, 16'(c0 + 16'd6));
    last = val;
    step(1);
    chk(flag == 1'b0, "R5 one cycle fall", flag, 0);
  endtask

  task automatic t_sel_toggle;
    sel = 1'b1; step(1);
    sel = 1'b0; step(1);
    sel = 1'b1;
    quiet(5, "R9 polarity change");
  endtask

  task automatic t_filt_capture;
    logic [15:0] c0;
    fen = 1'b1; sel = 1'b1;
    step(2);
    pin = 1'b1; c0 = cnt;
    for (int i = 0; i < 5; i++) begin
      step(1);
      chk(flag == 1'b0, "R6 early", flag, 0);
    end
    step(1);
    chk(flag == 1'b1, "R6 flag", flag, 1);
    chk(val == 16'(c0 + 16'd15), "R6 value", val, 16'(c0 + 16'd15));
    last = val;
  endtask

  task automatic t_filt_dropout;
    step(3);
    pin = 1'b0; step(2);
    pin = 1'b1;
    quiet(10, "R8 dropout");
  endtask

  task automatic t_filt_glitch;
    logic [15:0] c0;
    pin = 1'b0;
    quiet(8, "R4 filtered fall");
    pin = 1'b1; step(3);
    pin = 1'b0;
    quiet(10, "R7 short pulse");
    pin = 1'b1; c0 = cnt;
    step(4);
    pin = 1'b0;
    step(2);
    chk(flag == 1'b1, "R7 four-cycle pulse", flag, 1);
    chk(val == 16'(c0 + 16'd15), "R7 value", val, 16'(c0 + 16'd15));
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    t_reset();
    t_rise();
    t_fall();
    t_sel_toggle();
    t_filt_capture();
    t_filt_dropout();
    t_filt_glitch();
    step(3);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #(8 * 100000);
    total++; failed++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule